// File: doc/BRIEF.md
# Two-Level Tiled Triangle Rasterizer

The block turns one screen-space triangle, given as three signed integer vertices, into a stream of covered pixel positions. A triangle is taken on a valid/ready input port. The block then works through it in two passes.

A setup cycle fixes the winding and clamps the triangle's bounding box to the screen. A coarse pass then visits aligned 8x8 tiles over that box and tests each tile against the three edges. A fine pass walks every pixel of each tile the coarse pass keeps. Pixels that are inside all three edges and inside the clamped box leave on a valid/ready fragment port as (x, y).

The block holds one triangle at a time. It is meant to feed a fragment pipeline that may apply backpressure.

Top module: `tile_raster`

## Requirements
- R1: While reset is asserted and right after it is released, `tri_ready` is 1 and `frag_valid` is 0.
- R2: A triangle is taken on a clock edge where `tri_valid` and `tri_ready` are both 1. From the next cycle `tri_ready` stays 0 until the triangle is finished. `tri_valid` and the vertex inputs have no effect while `tri_ready` is 0, and no fragment is valid while `tri_ready` is 1.
- R3: Edge i runs from vertex i to vertex (i+1) mod 3, with E(x,y) = (x-xa)*(yb-ya) - (y-ya)*(xb-xa). A pixel is inside if E > 0 on every edge. E = 0 also counts as inside, but only on a left edge (yb-ya > 0) or a top edge (yb-ya = 0 and xb-xa < 0). Two triangles that share an edge never emit the same pixel.
- R4: The signed area A = E01(x2,y2) fixes the winding. When A < 0, vertices 1 and 2 are swapped, so both windings of a triangle give the same fragment stream.
- R5: A triangle with A = 0, or one whose bounding box lies fully off screen, gives no fragments. It keeps `tri_ready` low for exactly one cycle.
- R6: Every fragment satisfies 0 <= x < SCREEN_W and 0 <= y < SCREEN_H, and lies inside the triangle's bounding box.
- R7: Tiles are aligned to multiples of 8 and visited in raster order (x then y) across the clamped bounding box. Pixels inside a tile come out in raster order.
- R8: A tile is kept when, for every edge, E is >= 0 at the tile corner that is most inside for that edge. That corner takes the tile's right column when yb-ya > 0, and the tile's bottom row when xb-xa < 0. With `frag_ready` held at 1, a triangle keeps `tri_ready` low for 1 + T + 64*K cycles, where T is the number of tiles visited and K the number kept.
- R9: While `frag_valid` is 1 and `frag_ready` is 0, the fragment stays valid and `frag_x`/`frag_y` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tri_valid | input | 1 | Triangle offered |
| tri_ready | output | 1 | Block idle, triangle can be taken |
| tri_x0 | input | CW | Vertex 0 x, signed |
| tri_y0 | input | CW | Vertex 0 y, signed |
| tri_x1 | input | CW | Vertex 1 x, signed |
| tri_y1 | input | CW | Vertex 1 y, signed |
| tri_x2 | input | CW | Vertex 2 x, signed |
| tri_y2 | input | CW | Vertex 2 y, signed |
| frag_valid | output | 1 | Covered pixel available |
| frag_ready | input | 1 | Consumer takes the pixel |
| frag_x | output | clog2(SCREEN_W) | Pixel column |
| frag_y | output | clog2(SCREEN_H) | Pixel row |

## Verification
The assertions assume that `frag_ready` is a clean level driven from the consumer, and that vertex coordinates fit in CW signed bits, so that edge products cannot overflow the edge-value width. The stimulus keeps every vertex within a few hundred pixels of the screen and changes `frag_ready` only just after a clock edge. The bench raises `tri_valid` during a busy period only to show that it is ignored, and always lowers it again before the block can become ready.

// File: rtl/tile_raster.sv
module tile_raster #(
  parameter int CW        = 12,
  parameter int SCREEN_W  = 640,
  parameter int SCREEN_H  = 480,
  parameter int TILE_LOG2 = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tri_valid,
  output logic                        tri_ready,
  input  logic signed [CW-1:0]        tri_x0,
  input  logic signed [CW-1:0]        tri_y0,
  input  logic signed [CW-1:0]        tri_x1,
  input  logic signed [CW-1:0]        tri_y1,
  input  logic signed [CW-1:0]        tri_x2,
  input  logic signed [CW-1:0]        tri_y2,
  output logic                        frag_valid,
  input  logic                        frag_ready,
  output logic [$clog2(SCREEN_W)-1:0] frag_x,
  output logic [$clog2(SCREEN_H)-1:0] frag_y
);
  localparam int XW   = $clog2(SCREEN_W);
  localparam int YW   = $clog2(SCREEN_H);
  localparam int EW   = 2*CW + 3;
  localparam int TILE = 1 << TILE_LOG2;
  localparam logic signed [CW-1:0] XLIM  = CW'(SCREEN_W - 1);
  localparam logic signed [CW-1:0] YLIM  = CW'(SCREEN_H - 1);
  localparam logic signed [CW-1:0] TSTEP = CW'(TILE);
  localparam logic signed [CW-1:0] TLAST = CW'(TILE - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_COARSE, S_FINE} st_t;
  st_t st;

  logic signed [CW-1:0] vx [3];
  logic signed [CW-1:0] vy [3];
  logic signed [CW-1:0] bx0, bx1, by0, by1;
  logic signed [CW-1:0] tx, ty, px, py;

  function automatic logic signed [CW:0] sdiff(input logic signed [CW-1:0] a, input logic signed [CW-1:0] b);
    logic signed [CW:0] ea, eb;
    ea = a;
    eb = b;
    return ea - eb;
  endfunction

  function automatic logic signed [EW-1:0] edge_fn(input logic signed [CW:0] rx, input logic signed [CW:0] ry,
                                                   input logic signed [CW:0] ex, input logic signed [CW:0] ey);
    logic signed [EW-1:0] a, b, c, d;
    a = rx; b = ry; c = ex; d = ey;
    return a*d - b*c;
  endfunction

  function automatic logic signed [CW-1:0] smin(input logic signed [CW-1:0] a, input logic signed [CW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic signed [CW-1:0] smax(input logic signed [CW-1:0] a, input logic signed [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic signed [CW-1:0] align(input logic signed [CW-1:0] v);
    return {v[CW-1:TILE_LOG2], {TILE_LOG2{1'b0}}};
  endfunction

  logic signed [CW:0]   dx [3];
  logic signed [CW:0]   dy [3];
  logic signed [EW-1:0] ev [3];
  logic [2:0] pix_ok, tile_ok;

  for (genvar i = 0; i < 3; i++) begin : g_edge
    localparam int J = (i + 1) % 3;
    logic tl;
    logic signed [CW-1:0] cx, cy, qx, qy;
    assign dx[i] = sdiff(vx[J], vx[i]);
    assign dy[i] = sdiff(vy[J], vy[i]);
    assign tl = (dy[i] > 0) || (dy[i] == 0 && dx[i] < 0);
    assign cx = (dy[i] > 0) ? tx + TLAST : tx;
    assign cy = (dx[i] < 0) ? ty + TLAST : ty;
    assign qx = (st == S_COARSE) ? cx : px;
    assign qy = (st == S_COARSE) ? cy : py;
    assign ev[i] = edge_fn(sdiff(qx, vx[i]), sdiff(qy, vy[i]), dx[i], dy[i]);
    assign pix_ok[i]  = tl ? (ev[i] >= 0) : (ev[i] > 0);
    assign tile_ok[i] = (ev[i] >= 0);
  end

  logic signed [EW-1:0] area;
  logic signed [CW-1:0] lox, hix, loy, hiy;
  logic empty;
  assign area  = edge_fn(sdiff(vx[2], vx[0]), sdiff(vy[2], vy[0]), dx[0], dy[0]);
  assign lox   = smax(smin(smin(vx[0], vx[1]), vx[2]), '0);
  assign hix   = smin(smax(smax(vx[0], vx[1]), vx[2]), XLIM);
  assign loy   = smax(smin(smin(vy[0], vy[1]), vy[2]), '0);
  assign hiy   = smin(smax(smax(vy[0], vy[1]), vy[2]), YLIM);
  assign empty = (lox > hix) || (loy > hiy);

  logic in_box, pix_hit, tile_hit, last_px, tile_step, last_col, last_row;
  assign in_box    = (px >= bx0) && (px <= bx1) && (py >= by0) && (py <= by1);
  assign pix_hit   = in_box && (&pix_ok);
  assign tile_hit  = &tile_ok;
  assign last_px   = (px == tx + TLAST) && (py == ty + TLAST);
  assign last_col  = (tx == align(bx1));
  assign last_row  = (ty == align(by1));
  assign tile_step = (st == S_COARSE && !tile_hit) ||
                     (st == S_FINE && last_px && (!pix_hit || frag_ready));

  assign tri_ready  = (st == S_IDLE);
  assign frag_valid = (st == S_FINE) && pix_hit;
  assign frag_x     = px[XW-1:0];
  assign frag_y     = py[YW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int k = 0; k < 3; k++) begin
        vx[k] <= '0;
        vy[k] <= '0;
      end
      {bx0, bx1, by0, by1} <= '0;
      {tx, ty, px, py} <= '0;
    end else begin
      case (st)
        S_IDLE: if (tri_valid) begin
          vx[0] <= tri_x0; vy[0] <= tri_y0;
          vx[1] <= tri_x1; vy[1] <= tri_y1;
          vx[2] <= tri_x2; vy[2] <= tri_y2;
          st <= S_SETUP;
        end
        S_SETUP: begin
          if (area == 0 || empty) st <= S_IDLE;
          else begin
            if (area < 0) begin
              vx[1] <= vx[2]; vy[1] <= vy[2];
              vx[2] <= vx[1]; vy[2] <= vy[1];
            end
            bx0 <= lox; bx1 <= hix; by0 <= loy; by1 <= hiy;
            tx <= align(lox);
            ty <= align(loy);
            st <= S_COARSE;
          end
        end
        S_COARSE: if (tile_hit) begin
          px <= tx;
          py <= ty;
          st <= S_FINE;
        end
        S_FINE: if (!pix_hit || frag_ready) begin
          if (px == tx + TLAST) begin
            px <= tx;
            py <= py + 1'b1;
          end else begin
            px <= px + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (tile_step) begin
        if (!last_col) begin
          tx <= tx + TSTEP;
          st <= S_COARSE;
        end else if (!last_row) begin
          tx <= align(bx0);
          ty <= ty + TSTEP;
          st <= S_COARSE;
        end else begin
          st <= S_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/tile_raster_chk.sv
module tile_raster_chk #(
  parameter int SCREEN_W = 640,
  parameter int SCREEN_H = 480,
  parameter int XW = 10,
  parameter int YW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tri_valid,
  input logic          tri_ready,
  input logic          frag_valid,
  input logic          frag_ready,
  input logic [XW-1:0] frag_x,
  input logic [YW-1:0] frag_y
);
  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_valid && tri_ready) |=> !tri_ready);

  assert_no_frag_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |-> !tri_ready);

  assert_on_screen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |-> (32'(frag_x) < SCREEN_W && 32'(frag_y) < SCREEN_H));

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_valid && !frag_ready) |=> (frag_valid && $stable(frag_x) && $stable(frag_y)));
endmodule

bind tile_raster tile_raster_chk #(
  .SCREEN_W(SCREEN_W), .SCREEN_H(SCREEN_H), .XW($clog2(SCREEN_W)), .YW($clog2(SCREEN_H))
) chk_i (
  .clk(clk), .rst_n(rst_n), .tri_valid(tri_valid), .tri_ready(tri_ready),
  .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_x(frag_x), .frag_y(frag_y)
);

// File: tb/tile_raster_tb_top.sv
module tile_raster_tb_top;
  localparam int CW = 12;
  localparam int SW = 640;
  localparam int SH = 480;
  localparam int MAXF = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic tri_valid = 1'b0;
  logic tri_ready;
  logic signed [CW-1:0] ix0 = '0, iy0 = '0, ix1 = '0, iy1 = '0, ix2 = '0, iy2 = '0;
  logic frag_valid;
  logic frag_ready = 1'b0;
  logic [9:0] fx;
  logic [8:0] fy;

  tile_raster #(.CW(CW), .SCREEN_W(SW), .SCREEN_H(SH), .TILE_LOG2(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .tri_valid(tri_valid), .tri_ready(tri_ready),
    .tri_x0(ix0), .tri_y0(iy0), .tri_x1(ix1), .tri_y1(iy1), .tri_x2(ix2), .tri_y2(iy2),
    .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_x(fx), .frag_y(fy)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit bp = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    frag_ready <= bp ? ((cyc % 3) != 1) : 1'b1;
  end

  int gx [MAXF];
  int gy [MAXF];
  int gn = 0;
  always @(negedge clk) begin
    if (frag_valid && frag_ready) begin
      if (gn < MAXF) begin
        gx[gn] = int'(fx);
        gy[gn] = int'(fy);
      end
      gn = gn + 1;
    end
  end

  int ex [MAXF];
  int ey [MAXF];
  int en, et, ek, ebusy;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int efn(int x, int y, int ax, int ay, int bx, int by);
    return (x - ax) * (by - ay) - (y - ay) * (bx - ax);
  endfunction

  task automatic ref_build(input int x0, input int y0, input int x1, input int y1, input int x2, input int y2);
    int vx[3], vy[3], a, lox, hix, loy, hiy;
    en = 0; et = 0; ek = 0; ebusy = 1;
    vx[0] = x0; vy[0] = y0;
    a = efn(x2, y2, x0, y0, x1, y1);
    if (a < 0) begin vx[1] = x2; vy[1] = y2; vx[2] = x1; vy[2] = y1; end
    else begin vx[1] = x1; vy[1] = y1; vx[2] = x2; vy[2] = y2; end
    lox = (x0 < x1) ? x0 : x1; lox = (x2 < lox) ? x2 : lox; if (lox < 0) lox = 0;
    loy = (y0 < y1) ? y0 : y1; loy = (y2 < loy) ? y2 : loy; if (loy < 0) loy = 0;
    hix = (x0 > x1) ? x0 : x1; hix = (x2 > hix) ? x2 : hix; if (hix > SW - 1) hix = SW - 1;
    hiy = (y0 > y1) ? y0 : y1; hiy = (y2 > hiy) ? y2 : hiy; if (hiy > SH - 1) hiy = SH - 1;
    if (a == 0 || lox > hix || loy > hiy) return;
    for (int ty = (loy / 8) * 8; ty <= (hiy / 8) * 8; ty += 8) begin
      for (int tx = (lox / 8) * 8; tx <= (hix / 8) * 8; tx += 8) begin
        bit keep = 1'b1;
        et++;
        for (int i = 0; i < 3; i++) begin
          int j = (i + 1) % 3;
          int ddx = vx[j] - vx[i];
          int ddy = vy[j] - vy[i];
          int cx = (ddy > 0) ? tx + 7 : tx;
          int cy = (ddx < 0) ? ty + 7 : ty;
          if (efn(cx, cy, vx[i], vy[i], vx[j], vy[j]) < 0) keep = 1'b0;
        end
        if (keep) begin
          ek++;
          for (int y = ty; y < ty + 8; y++) begin
            for (int x = tx; x < tx + 8; x++) begin
              bit ins = (x >= lox && x <= hix && y >= loy && y <= hiy);
              for (int i = 0; i < 3; i++) begin
                int j = (i + 1) % 3;
                int ddx = vx[j] - vx[i];
                int ddy = vy[j] - vy[i];
                int e = efn(x, y, vx[i], vy[i], vx[j], vy[j]);
                bit tl = (ddy > 0) || (ddy == 0 && ddx < 0);
                if (!(e > 0 || (e == 0 && tl))) ins = 1'b0;
              end
              if (ins && en < MAXF) begin ex[en] = x; ey[en] = y; en++; end
            end
          end
        end
      end
    end
    ebusy = 1 + et + 64 * ek;
  endtask

  task automatic run_tri(input int x0, input int y0, input int x1, input int y1, input int x2, input int y2,
                         input bit poke, output int busy, output int base, output int cnt);
    @(negedge clk);
    base = gn;
    ix0 = CW'(x0); iy0 = CW'(y0); ix1 = CW'(x1); iy1 = CW'(y1); ix2 = CW'(x2); iy2 = CW'(y2);
    tri_valid = 1'b1;
    @(negedge clk);
    tri_valid = 1'b0;
    busy = 0;
    while (!tri_ready) begin
      busy++;
      if (poke) begin
        tri_valid = (busy >= 2 && busy < 8);
        ix0 = CW'(200); iy0 = CW'(200); ix1 = CW'(260); iy1 = CW'(210); ix2 = CW'(220); iy2 = CW'(270);
      end
      @(negedge clk);
    end
    tri_valid = 1'b0;
    cnt = gn - base;
  endtask

  task automatic cmp_stream(input string tag, input int base, input int cnt);
    int bad = -1;
    check(cnt == en, tag, "fragment count", cnt, en);
    for (int i = 0; i < en && i < cnt; i++)
      if (bad < 0 && (gx[base + i] != ex[i] || gy[base + i] != ey[i])) bad = i;
    if (bad >= 0)
      check(1'b0, tag, "fragment x*1000+y in order", gx[base + bad] * 1000 + gy[base + bad], ex[bad] * 1000 + ey[bad]);
    else
      check(1'b1, tag, "fragment order", 0, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(tri_ready == 1'b1, "R1", "tri_ready in reset", int'(tri_ready), 1);
    check(frag_valid == 1'b0, "R1", "frag_valid in reset", int'(frag_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tri_ready == 1'b1 && frag_valid == 1'b0, "R1", "idle after release", int'(tri_ready), 1);
  endtask

  task automatic t_plain(input string tag, input int x0, input int y0, input int x1, input int y1, input int x2, input int y2);
    int busy, base, cnt;
    ref_build(x0, y0, x1, y1, x2, y2);
    run_tri(x0, y0, x1, y1, x2, y2, 1'b0, busy, base, cnt);
    cmp_stream(tag, base, cnt);
    check(busy == ebusy, "R8", "busy cycles", busy, ebusy);
  endtask

  task automatic t_winding();
    int busy, base, cnt;
    ref_build(3, 2, 40, 10, 12, 35);
    run_tri(3, 2, 40, 10, 12, 35, 1'b0, busy, base, cnt);
    cmp_stream("R3", base, cnt);
    run_tri(3, 2, 12, 35, 40, 10, 1'b0, busy, base, cnt);
    cmp_stream("R4", base, cnt);
    check(busy == ebusy, "R4", "busy cycles other winding", busy, ebusy);
  endtask

  task automatic t_shared_edge();
    int busy, base, cnt, overlap, total;
    bit seen [0:4095];
    for (int i = 0; i < 4096; i++) seen[i] = 1'b0;
    ref_build(0, 0, 30, 0, 0, 30);
    run_tri(0, 0, 30, 0, 0, 30, 1'b0, busy, base, cnt);
    cmp_stream("R3", base, cnt);
    for (int i = 0; i < cnt; i++) seen[gy[base + i] * 64 + gx[base + i]] = 1'b1;
    total = cnt;
    ref_build(30, 0, 30, 30, 0, 30);
    run_tri(30, 0, 30, 30, 0, 30, 1'b0, busy, base, cnt);
    cmp_stream("R3", base, cnt);
    overlap = 0;
    for (int i = 0; i < cnt; i++) if (seen[gy[base + i] * 64 + gx[base + i]]) overlap++;
    total += cnt;
    check(overlap == 0, "R3", "pixels emitted twice on shared edge", overlap, 0);
    check(total == 900, "R3", "pixels covering the square", total, 900);
  endtask

  task automatic t_empty(input string what, input int x0, input int y0, input int x1, input int y1, input int x2, input int y2);
    int busy, base, cnt;
    run_tri(x0, y0, x1, y1, x2, y2, 1'b0, busy, base, cnt);
    check(cnt == 0, "R5", {what, " fragments"}, cnt, 0);
    check(busy == 1, "R5", {what, " busy cycles"}, busy, 1);
  endtask

  task automatic t_clip(input int x0, input int y0, input int x1, input int y1, input int x2, input int y2);
    int busy, base, cnt, off;
    ref_build(x0, y0, x1, y1, x2, y2);
    run_tri(x0, y0, x1, y1, x2, y2, 1'b0, busy, base, cnt);
    cmp_stream("R6", base, cnt);
    off = 0;
    for (int i = 0; i < cnt; i++)
      if (gx[base + i] >= SW || gy[base + i] >= SH) off++;
    check(off == 0, "R6", "fragments off screen", off, 0);
    check(cnt > 0, "R6", "visible part produced", cnt, 1);
  endtask

  task automatic t_backpressure();
    int busy, base, cnt;
    bp = 1'b1;
    ref_build(5, 4, 37, 9, 14, 30);
    run_tri(5, 4, 37, 9, 14, 30, 1'b0, busy, base, cnt);
    cmp_stream("R9", base, cnt);
    check(busy > ebusy, "R9", "stalls lengthen the run", busy, ebusy + 1);
    bp = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    int busy, base, cnt;
    ref_build(10, 10, 50, 20, 20, 45);
    run_tri(10, 10, 50, 20, 20, 45, 1'b1, busy, base, cnt);
    cmp_stream("R2", base, cnt);
    check(busy == ebusy, "R2", "busy cycles with input toggled", busy, ebusy);
    repeat (3) @(negedge clk);
    check(gn == base + cnt, "R2", "fragments after finish", gn - base, cnt);
  endtask

  task automatic t_order();
    int busy, base, cnt, bad;
    ref_build(1, 1, 60, 3, 30, 40);
    run_tri(1, 1, 60, 3, 30, 40, 1'b0, busy, base, cnt);
    cmp_stream("R7", base, cnt);
    bad = 0;
    for (int i = 1; i < cnt; i++) begin
      int ta = (gy[base+i-1] / 8) * 1000 + gx[base+i-1] / 8;
      int tb = (gy[base+i] / 8) * 1000 + gx[base+i] / 8;
      int pa = (gy[base+i-1] % 8) * 8 + gx[base+i-1] % 8;
      int pb = (gy[base+i] % 8) * 8 + gx[base+i] % 8;
      if (tb < ta || (tb == ta && pb <= pa)) bad++;
    end
    check(bad == 0, "R7", "out-of-order fragments", bad, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: got %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_winding();
    t_shared_edge();
    t_empty("collinear", 5, 5, 20, 20, 35, 35);
    t_empty("off screen", -50, -50, -10, -40, -30, -5);
    t_clip(-30, -20, 50, 5, 10, 60);
    t_clip(620, 470, 700, 470, 620, 520);
    t_plain("R8", 2, 2, 120, 10, 4, 6);
    t_backpressure();
    t_busy_ignore();
    t_order();
    summary();
    $finish;
  end
endmodule